// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a clocked host read and write a 128K x 8 asynchronous static RAM. The host raises a request with a write flag, a 17-bit word address and a byte of write data. When the block is idle it accepts the request and captures all three values. It then drives the memory's pins through a fixed series of phases, each lasting a parameterised number of clock cycles. Finally it returns a one-cycle completion pulse, with the read byte valid in that same cycle.

The memory side has two chip selects of opposite sense, a write strobe, an output enable, an address bus and a shared data bus. The shared bus is split into an output byte, a drive-enable and an input byte, so that the pad ring can build the tristate.

Every memory pin is a flip-flop output, decoded from the sequencer's next phase. When nothing is in flight, the chip selects sit in the non-selected state. This lets other memories share the data bus. A write always ends on the write strobe's rising edge, while the chip is still selected. Output enable stays high for the whole write, so the controller and the memory never drive the bus together.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the pins are in standby: mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0. The host outputs host_busy and host_done are both 0.
- R2: Let T be the transaction's busy length (R9) and RCV = RECOV_CYC. The chip is selected (mem_cs1_n=0 and mem_cs2=1) exactly in cycles 1..T-RCV after acceptance. At every other time, including idle, mem_cs1_n=1 and mem_cs2=0.
- R3: A request is accepted on a clock edge where host_req=1 and host_busy=0. The address, write flag and write data are captured at that edge. Host inputs that change while busy have no effect on mem_addr or mem_dq_o.
- R4: For a write, mem_we_n is 0 exactly in cycles SETUP_CYC+1..SETUP_CYC+WPULSE_CYC after acceptance. For a read it stays 1.
- R5: A write ends when mem_we_n rises while the chip is selected. The chip stays selected for one further hold cycle after that rise.
- R6: For a write, mem_dq_oe is 1 exactly in cycles 1..SETUP_CYC+WPULSE_CYC+1 after acceptance, and mem_dq_o carries the captured data. For a read, mem_dq_oe stays 0.
- R7: For a read, mem_oe_n is 0 exactly in cycles SETUP_CYC+1..SETUP_CYC+RACC_CYC after acceptance. mem_oe_n is never 0 while mem_dq_oe=1 or while mem_we_n=0.
- R8: Read data is the value of mem_dq_i during the last cycle in which mem_oe_n is 0. It appears on host_rdata in the completion cycle.
- R9: host_busy is 1 in cycles 1..T after acceptance, and host_done is 1 for exactly one cycle, at cycle T+1. T is SETUP_CYC+WPULSE_CYC+1+RECOV_CYC for a write, and SETUP_CYC+RACC_CYC+RECOV_CYC for a read. A new request may be accepted in the completion cycle.
- R10: mem_addr holds the captured address unchanged in every busy cycle, including the recovery cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Transaction request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Transaction in flight |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data returned from memory |

## Verification
Each result has a fixed due cycle. Count from the edge that accepts a request as cycle 1. The pins change on that edge. The write strobe falls after SETUP_CYC cycles, and output enable falls after SETUP_CYC cycles. host_done arrives one cycle after the last busy cycle. The bench's reference model keeps this cycle index from its own copy of the request stream. It compares every pin and host output against the value due for that index, half a period after each edge. Read data is compared in the completion cycle against a shadow store, which is updated when a write is accepted. The memory model, by contrast, stores what it sees at the strobe's rising edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_WPULSE,
      PH_WHOLD,
      PH_RWAIT,
      PH_RECOV
   } phase_e;

   function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic logic phase_selects(phase_e p);
      return (p == PH_SETUP) || (p == PH_WPULSE) || (p == PH_WHOLD) || (p == PH_RWAIT);
   endfunction
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned SETUP_CYC  = 1,
   parameter int unsigned WPULSE_CYC = 3,
   parameter int unsigned RACC_CYC   = 10,
   parameter int unsigned RECOV_CYC  = 1
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   start,
   input  logic   wr_q,
   output phase_e phase_q,
   output phase_e phase_d,
   output logic   capture,
   output logic   finish
);
   localparam int unsigned MAXC  = max_of4(SETUP_CYC, WPULSE_CYC, RACC_CYC, RECOV_CYC);
   localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

   generate
      if (SETUP_CYC < 1)  begin : g_bad_setup  $error("SETUP_CYC must be at least 1");  end
      if (WPULSE_CYC < 1) begin : g_bad_pulse  $error("WPULSE_CYC must be at least 1"); end
      if (RACC_CYC < 1)   begin : g_bad_racc   $error("RACC_CYC must be at least 1");   end
      if (RECOV_CYC < 1)  begin : g_bad_recov  $error("RECOV_CYC must be at least 1");  end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign capture  = (phase_q == PH_RWAIT) && cnt_zero;
   assign finish   = (phase_q == PH_RECOV) && cnt_zero;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
      unique case (phase_q)
         PH_IDLE: begin
            cnt_d = cnt_q;
            if (start) begin
               phase_d = PH_SETUP;
               cnt_d   = CNT_W'(SETUP_CYC - 1);
            end
         end
         PH_SETUP: if (cnt_zero) begin
            phase_d = wr_q ? PH_WPULSE : PH_RWAIT;
            cnt_d   = wr_q ? CNT_W'(WPULSE_CYC - 1) : CNT_W'(RACC_CYC - 1);
         end
         PH_WPULSE: if (cnt_zero) begin
            phase_d = PH_WHOLD;
            cnt_d   = '0;
         end
         PH_WHOLD: begin
            phase_d = PH_RECOV;
            cnt_d   = CNT_W'(RECOV_CYC - 1);
         end
         PH_RWAIT: if (cnt_zero) begin
            phase_d = PH_RECOV;
            cnt_d   = CNT_W'(RECOV_CYC - 1);
         end
         PH_RECOV: if (cnt_zero) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
         end
         default: begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   // R9: a transaction is only started from idle
   assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (rst)
      start |-> (phase_q == PH_IDLE));
   // R5: hold phase always follows the strobe-low phase
   assert_hold_after_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_WHOLD) |-> ($past(phase_q) == PH_WPULSE));
endmodule

// File: rtl/sram_ctrl_hostif.sv
module sram_ctrl_hostif
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  phase_e            phase_q,
   input  logic              capture,
   input  logic              finish,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              start,
   output logic              wr_q,
   output logic              wr_eff,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   assign busy   = (phase_q != PH_IDLE);
   assign start  = host_req && !busy;
   assign wr_eff = start ? host_wr : wr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= finish;
         if (start) begin
            wr_q    <= host_wr;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
         end
         if (capture) rdata <= mem_dq_i;
      end
   end

   // R10: address held across the whole transaction
   assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(addr_q));
   // R9: completion is a single-cycle pulse while idle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   // R8: read byte only changes on a read completion path
   assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_WPULSE) |-> $stable(rdata));
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  phase_e phase_d,
   input  logic   wr_eff,
   output logic   cs1_n,
   output logic   cs2,
   output logic   we_n,
   output logic   oe_n,
   output logic   dq_oe
);
   logic sel_q;

   assign cs1_n = ~sel_q;
   assign cs2   = sel_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= 1'b0;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         sel_q <= phase_selects(phase_d);
         we_n  <= (phase_d != PH_WPULSE);
         oe_n  <= (phase_d != PH_RWAIT);
         dq_oe <= wr_eff && ((phase_d == PH_SETUP) || (phase_d == PH_WPULSE) ||
                             (phase_d == PH_WHOLD));
      end
   end

   // R7: no bus contention, no read during a write strobe
   assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
      !(dq_oe && !oe_n));
   assert_oe_we_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      !(!we_n && !oe_n));
   // R5: strobe low and its rising edge only while selected
   assert_we_selected_R5: assert property (@(posedge clk) disable iff (rst)
      !we_n |-> (!cs1_n && cs2));
   assert_we_rise_selected_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(we_n) |-> (!cs1_n && cs2));
   // R4: address set up before the strobe falls
   assert_we_setup_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(we_n) |-> $past(sel_q));
   // R6: data driven across the strobe's rising edge
   assert_dq_hold_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(we_n) |-> dq_oe);
   // R2: chip selects always opposite in sense
   assert_cs_pair_R2: assert property (@(posedge clk) disable iff (rst)
      cs1_n != cs2);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SETUP_CYC  = 1,
   parameter int unsigned WPULSE_CYC = 3,
   parameter int unsigned RACC_CYC   = 10,
   parameter int unsigned RECOV_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_done,
   output logic              host_busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   phase_e phase_q, phase_d;
   logic   start, wr_q, wr_eff, capture, finish;

   sram_ctrl_seq #(
      .SETUP_CYC(SETUP_CYC), .WPULSE_CYC(WPULSE_CYC),
      .RACC_CYC(RACC_CYC),   .RECOV_CYC(RECOV_CYC)
   ) u_seq (
      .clk(clk), .rst(rst), .start(start), .wr_q(wr_q),
      .phase_q(phase_q), .phase_d(phase_d), .capture(capture), .finish(finish)
   );

   sram_ctrl_hostif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
      .clk(clk), .rst(rst),
      .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .phase_q(phase_q), .capture(capture), .finish(finish),
      .mem_dq_i(mem_dq_i),
      .start(start), .wr_q(wr_q), .wr_eff(wr_eff),
      .addr_q(mem_addr), .wdata_q(mem_dq_o),
      .busy(host_busy), .done(host_done), .rdata(host_rdata)
   );

   sram_ctrl_pins u_pins (
      .clk(clk), .rst(rst), .phase_d(phase_d), .wr_eff(wr_eff),
      .cs1_n(mem_cs1_n), .cs2(mem_cs2), .we_n(mem_we_n),
      .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
   );

   // R2: idle always means standby on the memory
   assert_idle_standby_R2: assert property (@(posedge clk) disable iff (rst)
      !host_busy |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 17, DW = 8;
   localparam int S = 1, W = 3, A = 10, R = 1;
   localparam int TW = S + W + 1 + R;
   localparam int TR = S + A + R;

   logic          clk = 0, rst = 1;
   logic          host_req = 0, host_wr = 0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata, mem_dq_o;
   logic [DW-1:0] mem_dq_i = '0;
   logic          host_done, host_busy, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .WPULSE_CYC(W),
                     .RACC_CYC(A), .RECOV_CYC(R)) uut (
      .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_done(host_done), .host_busy(host_busy), .mem_addr(mem_addr),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, failures = 0, cycles = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // memory model driven from the pins
   logic [DW-1:0] sram   [logic [AW-1:0]];
   logic [DW-1:0] shadow [logic [AW-1:0]];
   logic prev_we_n = 1;

   function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
      return sram.exists(a) ? sram[a] : 8'hA5;
   endfunction
   function automatic logic [DW-1:0] shd_rd(input logic [AW-1:0] a);
      return shadow.exists(a) ? shadow[a] : 8'hA5;
   endfunction

   always @(negedge clk) begin
      if (!mem_cs1_n && mem_cs2 && prev_we_n == 0 && mem_we_n && mem_dq_oe)
         sram[mem_addr] = mem_dq_o;
      prev_we_n = mem_we_n;
      mem_dq_i <= (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n) ? mem_rd(mem_addr) : 8'h00;
   end

   // reference model: cycle index since acceptance
   int            t = 0;
   bit            m_wr = 0, done_e = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0, m_rd = '0;

   function automatic int tlen(input bit w);
      return w ? TW : TR;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         t <= 0; done_e <= 0;
      end else begin
         done_e <= (t != 0) && (t == tlen(m_wr));
         if (t != 0) begin
            t <= (t == tlen(m_wr)) ? 0 : t + 1;
         end else if (host_req) begin
            t <= 1; m_wr <= host_wr; m_addr <= host_addr; m_data <= host_wdata;
            if (host_wr) shadow[host_addr] = host_wdata;
            else m_rd <= shd_rd(host_addr);
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst) begin
         if (cycles > 1) begin
            chk(mem_cs1_n === 1 && mem_cs2 === 0, "R1 chip selects", {mem_cs1_n, mem_cs2}, 2);
            chk(mem_we_n === 1 && mem_oe_n === 1 && mem_dq_oe === 0, "R1 strobes",
                {mem_we_n, mem_oe_n, mem_dq_oe}, 6);
            chk(host_busy === 0 && host_done === 0, "R1 host", {host_busy, host_done}, 0);
         end
      end else if (!finished) begin
         bit sel_e, we_e, oe_e, dqoe_e, busy_e;
         busy_e = (t != 0);
         sel_e  = busy_e && (t <= tlen(m_wr) - R);
         we_e   = !(busy_e && m_wr && t >= S + 1 && t <= S + W);
         oe_e   = !(busy_e && !m_wr && t >= S + 1 && t <= S + A);
         dqoe_e = busy_e && m_wr && t <= S + W + 1;
         chk(mem_cs1_n === !sel_e && mem_cs2 === sel_e, "R2 chip select",
             {mem_cs1_n, mem_cs2}, {!sel_e, sel_e});
         chk(mem_we_n === we_e, "R4 R5 write strobe", mem_we_n, we_e);
         chk(mem_oe_n === oe_e, "R7 output enable", mem_oe_n, oe_e);
         chk(mem_dq_oe === dqoe_e, "R6 data drive", mem_dq_oe, dqoe_e);
         chk(host_busy === busy_e, "R9 busy", host_busy, busy_e);
         chk(host_done === done_e, "R9 done", host_done, done_e);
         if (busy_e) chk(mem_addr === m_addr, "R3 R10 address", mem_addr, m_addr);
         if (dqoe_e) chk(mem_dq_o === m_data, "R3 R6 write data", mem_dq_o, m_data);
         if (done_e && !m_wr) chk(host_rdata === m_rd, "R8 read data", host_rdata, m_rd);
      end
   end

   task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_req = 1; host_wr = w; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_req = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (t != 0) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 0;
      // R1..R9: basic writes and reads, address extremes
      issue(1, 17'h00000, 8'h3C); wait_idle();
      issue(1, 17'h1FFFF, 8'hC3); wait_idle();
      issue(0, 17'h00000, 8'h00); wait_idle();
      issue(0, 17'h1FFFF, 8'h00); wait_idle();
      issue(0, 17'h0BEEF, 8'h00); wait_idle();   // never written: default byte
      // R3: inputs churn while busy must be ignored
      @(negedge clk);
      host_req = 1; host_wr = 1; host_addr = 17'h12345; host_wdata = 8'h5A;
      @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         host_addr = 17'(i * 977); host_wdata = 8'(i * 29); host_wr = i[0];
         @(negedge clk);
      end
      host_req = 0;
      wait_idle();
      issue(0, 17'h12345, 8'h00); wait_idle();
      // R9: request held high gives back-to-back transactions from the done cycle
      @(negedge clk);
      for (int i = 0; i < 60; i++) begin
         host_req = 1; host_wr = (i % 3) != 2; host_addr = 17'(i % 4);
         host_wdata = 8'(8'h80 + i);
         @(negedge clk);
      end
      host_req = 0;
      wait_idle();
      for (int i = 0; i < 4; i++) begin
         issue(0, 17'(i), 8'h00); wait_idle();
      end
      // R8: overwrite then read
      issue(1, 17'h00000, 8'hE7); wait_idle();
      issue(0, 17'h00000, 8'h00); wait_idle();
      repeat (3) @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule